// File: doc/BRIEF.md
# Clock Output Gate Controller

This block sits between a set of eight internally generated clocks and their output pads. For every lane it produces a pad data signal and a pad output-enable signal. Three controls decide whether a lane is running: an individual enable on the even lanes, one master enable for the whole bank, and an active-low power-down input. When a lane is stopped, a per-lane type bit selects how the pad behaves. It can float, or it can be held actively low.

The block never cuts a clock pulse short. Each enable decision passes through a two-flop synchroniser clocked by that lane's own clock. The gate then moves only on the lane clock's falling edge, so the pad changes only while the clock is low. Lanes whose pad is in use as a control input are kept in high impedance. The block also produces two signals for the upstream clock sources. One asks them to stop when power-down is asserted. The other reports them as off whenever the master enable or power-down is stopping the bank.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: Lane i runs only when all three of its controls allow it: its individual enable is 1 (even lanes only, lane i uses `ind_en[i/2]`), `master_en` is 1, and `pd_n` is 1. A running lane has `pad_oe[i]`=1 and a `pad_dout[i]` that toggles with `clk_in[i]`.
- R2: Odd lanes have no individual enable. `ind_en` has no effect on them.
- R3: A stopped lane keeps `pad_dout[i]`=0. If `dis_low[i]`=1 it drives low with `pad_oe[i]`=1. If `dis_low[i]`=0 it floats with `pad_oe[i]`=0.
- R4: While `pin_is_ctrl[i]`=1, `pad_oe[i]` is 0, whatever the enable controls are.
- R5: The gate of a lane changes only while that lane's clock is low. Every high pulse on `pad_dout[i]` lasts exactly half a period of `clk_in[i]`.
- R6: After a lane's controls change to allow it, its first full high pulse begins no later than the third rising edge of its clock.
- R7: `src_stop` is 1 exactly when `pd_n` is 0.
- R8: `src_off` is 1 when `master_en` is 0 or `pd_n` is 0, and is 0 otherwise.
- R9: While `rst_n` is 0, every lane is in its stopped state as given by R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 8 | Generated clocks, one per lane |
| rst_n | input | 1 | Asynchronous active-low reset |
| ind_en | input | 4 | Individual enables for lanes 0, 2, 4 and 6, 1 = run |
| master_en | input | 1 | Bank enable, 0 stops every lane |
| pd_n | input | 1 | Power-down, active low |
| dis_low | input | 8 | Stopped-state type per lane: 0 = float, 1 = drive low |
| pin_is_ctrl | input | 8 | Lane pad is used as a control input |
| pad_dout | output | 8 | Pad data |
| pad_oe | output | 8 | Pad output enable |
| src_stop | output | 1 | Request to stop oscillator, PLLs and counters |
| src_off | output | 1 | Reports the clock sources as off |

## Verification
The bench steps through all 64 combinations of the individual enables, the master enable and power-down. Each combination uses a different type-bit pattern and some of them set control-pin lanes. This set would expose a design that lets `ind_en` reach an odd lane, one that swaps float and drive-low, and one that drives a pad in use as an input. Every high pulse on every pad is timed. A gate that moved on the rising edge, or straight from the asynchronous input, would show up as a shortened pulse. A separate measurement from an enable change to the first pad pulse would catch an extra pipeline stage.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  // Even lanes own an individual enable; odd lanes have none.
  function automatic bit lane_has_ind(input int lane);
    return (lane % 2) == 0;
  endfunction

  function automatic int lane_ind_idx(input int lane);
    return lane / 2;
  endfunction
endpackage

// File: rtl/clkgate_sync2.sv
module clkgate_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = d;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic want_en,
  input  logic dis_low,
  input  logic is_ctrl,
  output logic pad_dout,
  output logic pad_oe,
  output logic gate
);
  logic en_s;
  logic gate_q, gate_d, gate_ce;

  clkgate_sync2 #(.RST_VAL(1'b0)) u_en_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (want_en),
    .q    (en_s)
  );

  always_comb begin
    gate_d  = en_s;
    gate_ce = (en_s != gate_q);
  end

  // Updated on the falling edge, while the lane clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= 1'b0;
    else if (gate_ce) gate_q <= gate_d;
  end

  assign pad_dout = clk & gate_q;
  assign pad_oe   = ~is_ctrl & (gate_q | dis_low);
  assign gate     = gate_q;
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl #(
  parameter  int N_LANES = 8,
  localparam int N_IND   = (N_LANES + 1) / 2
) (
  input  logic [N_LANES-1:0] clk_in,
  input  logic               rst_n,
  input  logic [N_IND-1:0]   ind_en,
  input  logic               master_en,
  input  logic               pd_n,
  input  logic [N_LANES-1:0] dis_low,
  input  logic [N_LANES-1:0] pin_is_ctrl,
  output logic [N_LANES-1:0] pad_dout,
  output logic [N_LANES-1:0] pad_oe,
  output logic               src_stop,
  output logic               src_off
);
  import clkgate_pkg::*;

  logic               bank_en;
  logic [N_LANES-1:0] want_en;
  logic [N_LANES-1:0] lane_rst_n;
  logic [N_LANES-1:0] lane_gate;

  assign bank_en  = master_en & pd_n;
  assign src_stop = ~pd_n;
  assign src_off  = ~bank_en;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    if (lane_has_ind(g)) begin : g_ind
      assign want_en[g] = ind_en[lane_ind_idx(g)] & bank_en;
    end else begin : g_noind
      assign want_en[g] = bank_en;
    end

    // Reset asserts asynchronously, releases on this lane's clock.
    clkgate_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
      .clk  (clk_in[g]),
      .rst_n(rst_n),
      .d    (1'b1),
      .q    (lane_rst_n[g])
    );

    clkgate_lane u_lane (
      .clk     (clk_in[g]),
      .rst_n   (lane_rst_n[g]),
      .want_en (want_en[g]),
      .dis_low (dis_low[g]),
      .is_ctrl (pin_is_ctrl[g]),
      .pad_dout(pad_dout[g]),
      .pad_oe  (pad_oe[g]),
      .gate    (lane_gate[g])
    );
  end
endmodule

// File: rtl/clkout_gate_ctrl_chk.sv
module clkout_gate_ctrl_chk #(
  parameter int N_LANES = 8,
  parameter int N_IND   = 4
) (
  input logic [N_LANES-1:0] clk_in,
  input logic               rst_n,
  input logic [N_IND-1:0]   ind_en,
  input logic               master_en,
  input logic               pd_n,
  input logic [N_LANES-1:0] dis_low,
  input logic [N_LANES-1:0] pin_is_ctrl,
  input logic [N_LANES-1:0] pad_dout,
  input logic [N_LANES-1:0] pad_oe,
  input logic               src_stop,
  input logic               src_off,
  input logic [N_LANES-1:0] gate
);
  always_comb begin
    AST_STOP_REQ: assert (src_stop == ~pd_n);                 // R7
    AST_SRC_OFF:  assert (src_off == ~(master_en & pd_n));    // R8
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_chk
    logic en_g;
    logic [2:0] run_cnt;
    if ((g % 2) == 0) begin : g_i
      assign en_g = ind_en[g/2] & master_en & pd_n;
    end else begin : g_n
      assign en_g = master_en & pd_n;
    end

    always_ff @(posedge clk_in[g] or negedge rst_n) begin
      if (!rst_n)              run_cnt <= 3'd0;
      else if (run_cnt != 3'd7) run_cnt <= run_cnt + 3'd1;
    end

    always_comb begin
      if (pin_is_ctrl[g]) AST_CTRL_FLOAT: assert (!pad_oe[g]); // R4
    end

    always @(gate[g]) begin
      if (rst_n) AST_GATE_WHILE_LOW: assert (clk_in[g] == 1'b0); // R5
    end

    AST_LANE_ON: assert property (@(posedge clk_in[g]) disable iff (!rst_n)
      (run_cnt == 3'd7 && en_g && $past(en_g) && $past(en_g, 2))
      |=> (pad_oe[g] == ~pin_is_ctrl[g]));                      // R1

    AST_LANE_OFF: assert property (@(posedge clk_in[g]) disable iff (!rst_n)
      (run_cnt == 3'd7 && !pd_n && $past(!pd_n) && $past(!pd_n, 2))
      |=> (pad_oe[g] == (dis_low[g] & ~pin_is_ctrl[g])));       // R3
  end
endmodule

bind clkout_gate_ctrl clkout_gate_ctrl_chk #(.N_LANES(N_LANES), .N_IND(N_IND)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .ind_en(ind_en), .master_en(master_en),
  .pd_n(pd_n), .dis_low(dis_low), .pin_is_ctrl(pin_is_ctrl),
  .pad_dout(pad_dout), .pad_oe(pad_oe), .src_stop(src_stop),
  .src_off(src_off), .gate(lane_gate)
);

// File: tb/clkout_gate_ctrl_tb.sv
`timescale 1ns/100ps
module clkout_gate_ctrl_tb;
  localparam int CLK_PERIOD = 10;  // lane g runs at CLK_PERIOD + 2*g
  localparam int NL = 8;

  logic [NL-1:0] clk_in;
  logic          rst_n;
  logic [3:0]    ind_en;
  logic          master_en, pd_n;
  logic [NL-1:0] dis_low, pin_is_ctrl;
  logic [NL-1:0] pad_dout, pad_oe;
  logic          src_stop, src_off;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int pcnt [NL];

  typedef struct {
    logic [NL-1:0] oe;
    logic [NL-1:0] act;
    logic          stop;
    logic          off;
  } exp_t;
  exp_t sb_q[$];

  clkout_gate_ctrl u_dut (
    .clk_in(clk_in), .rst_n(rst_n), .ind_en(ind_en), .master_en(master_en),
    .pd_n(pd_n), .dis_low(dis_low), .pin_is_ctrl(pin_is_ctrl),
    .pad_dout(pad_dout), .pad_oe(pad_oe), .src_stop(src_stop), .src_off(src_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  for (genvar g = 0; g < NL; g++) begin : g_clk
    initial begin
      clk_in[g] = 1'b0;
      forever #((CLK_PERIOD + 2*g) / 2.0) clk_in[g] = ~clk_in[g];
    end
    realtime t_rise;
    initial pcnt[g] = 0;
    always @(posedge pad_dout[g]) begin
      t_rise = $realtime;
      pcnt[g]++;
    end
    // R5: every high pulse is exactly half a lane period
    always @(negedge pad_dout[g]) begin
      if (rst_n)
        chk("R5 pulse width x10", int'(($realtime - t_rise) * 10.0),
            (CLK_PERIOD + 2*g) * 5);
    end
  end

  // Driver: apply controls, compute the expected pad state, push it.
  task automatic apply(input logic [3:0] ie, input logic me, input logic pn,
                       input logic [NL-1:0] lo, input logic [NL-1:0] ct);
    exp_t e;
    ind_en = ie; master_en = me; pd_n = pn; dis_low = lo; pin_is_ctrl = ct;
    for (int i = 0; i < NL; i++) begin
      logic en;
      en = ((i % 2 == 1) ? 1'b1 : ie[i/2]) & me & pn;   // R1, R2
      e.act[i] = en;
      e.oe[i]  = ~ct[i] & (en | lo[i]);                 // R3, R4
    end
    e.stop = ~pn;                                        // R7
    e.off  = ~(me & pn);                                 // R8
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
    #0.5;
  endtask

  // Monitor: let the lanes settle, observe a window, compare.
  initial begin
    forever begin
      int base [NL];
      exp_t e;
      wait (sb_q.size() != 0);
      #100;
      for (int i = 0; i < NL; i++) base[i] = pcnt[i];
      #60.5;
      e = sb_q[0];
      for (int i = 0; i < NL; i++) begin
        chk("R1/R2 lane toggles", 32'(pcnt[i] != base[i]), 32'(e.act[i]));
        if (!e.act[i]) chk("R3 stopped dout", 32'(pad_dout[i]), 32'd0);
      end
      chk("R1/R3/R4 pad_oe", 32'(pad_oe), 32'(e.oe));
      chk("R7 src_stop", 32'(src_stop), 32'(e.stop));
      chk("R8 src_off", 32'(src_off), 32'(e.off));
      void'(sb_q.pop_front());
    end
  end

  initial begin
    #150000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    realtime t0;
    rst_n = 1'b0; ind_en = 4'hF; master_en = 1'b1; pd_n = 1'b1;
    dis_low = 8'hA5; pin_is_ctrl = 8'h00;
    #50.5;
    // R9: reset state
    chk("R9 reset pad_oe", 32'(pad_oe), 32'h A5);
    chk("R9 reset pad_dout", 32'(pad_dout), 32'h0);
    chk("R7 reset src_stop", 32'(src_stop), 32'h0);
    #49.5;
    rst_n = 1'b1;
    #200;
    // Every enable combination, with changing type bits and control pins.
    for (int c = 0; c < 64; c++) begin
      logic [7:0] lo, ct;
      lo = 8'(c * 37) ^ 8'h5A;
      ct = ((c % 8) == 3) ? 8'h81 : ((c % 8) == 6 ? 8'h14 : 8'h00);
      apply(c[3:0], c[4], c[5], lo, ct);
    end
    apply(4'h0, 1'b1, 1'b1, 8'hFF, 8'h00);  // R2: odd lanes still run
    apply(4'hF, 1'b1, 1'b0, 8'h00, 8'h00);  // R3 float under power-down
    apply(4'hF, 1'b1, 1'b0, 8'hFF, 8'h00);  // R3 drive low under power-down
    // R6: latency from releasing lane 6's enable to its first pulse
    apply(4'h0, 1'b1, 1'b1, 8'h00, 8'h00);
    t0 = $realtime;
    ind_en[3] = 1'b1;
    @(posedge pad_dout[6]);
    chk("R6 first pulse within 3 periods", 32'($realtime - t0 <= 3.0 * (CLK_PERIOD + 12)), 32'd1);
    #100;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule